// File: doc/BRIEF.md
# Readback and Analog Window Sequencer

This block drives the reply side of a single shared serial line. The line also carries the analog output. When the receiver decodes a readback command, the block picks one byte from the interface fields with a four-bit read selector. It leaves the line released for one byte time so the host can turn its driver around. It then sends the byte as one frame with a start bit, eight data bits and a stop bit, at the bit period the receiver learned, and releases the line again.

When the receiver decodes an analog output command, the block keeps the serial driver off. It enables the analog output path for a window whose length in byte times comes from a four-bit window code. The all-ones code selects a continuous mode. In that mode the analog path stays on, and new commands are accepted again only after a long fixed window.

A `busy` flag covers the whole reply or window, and the receiver uses it to hold off decoding. One byte time is always eight bit periods.

Top module: `readback_window_seq`

## Requirements
- R1: After reset, `line_oe` and `ana_oe` are 0, `busy` is 0 and `line_out` is 1.
- R2: A readback request accepted at clock edge k makes `busy` 1 from edge k on. The line stays released (`line_oe` 0, `line_out` 1) for 8·P cycles, where P is `bit_period`.
- R3: After the gap, `line_oe` is 1 for 10·P cycles. `line_out` carries a low start bit, then the reply byte least significant bit first, then a high stop bit, each bit held for P cycles. After that the line is released and `busy` returns to 0, 18·P cycles after edge k. While released, `line_out` is 1.
- R4: The reply byte follows `rd_sel`, sampled at acceptance. The values 0 and 1 select `hold_word` bits [7:0] and [15:8]. Value 2 selects {`mem_addr`[7:4], `cal_addr`}. Value 3 selects {`cmd_code`, `rd_sel`}. Value 4 selects {`ana_sel`, `win_code`}. Values 5 to 8 select `mem_addr`, `mem_byte`, `temp_index` and `rate_count` in that order. In each concatenation the first field is the upper nibble.
- R5: `rd_sel` value 9 returns 8'h00, and values 10 to 15 return the check byte 8'hCA.
- R6: An analog request with `win_code` T below 15 sets `ana_oe` and `busy` to 1 for 8·(2^T+1)·P cycles from the accepting edge, then clears both. `line_oe` stays 0 throughout, and `ana_oe` and `line_oe` are never 1 together.
- R7: With `win_code` 15, `busy` stays 1 for 8·(2^C+1)·P cycles, where C is the parameter CONT_WIN_LOG2 (default 15, that is 32,769 byte times). `ana_oe` stays 1 after that window ends and is cleared only when a readback request is accepted.
- R8: Requests that arrive while `busy` is 1 are ignored. The reply, the window and the outputs continue unchanged.
- R9: If both requests arrive in the same idle cycle, the readback is taken and the analog request is dropped.
- R10: A `bit_period` of 0 behaves as a period of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Readback command strobe |
| ana_req | input | 1 | Analog output command strobe |
| rd_sel | input | 4 | Read selector |
| hold_word | input | 16 | Data holding word |
| mem_addr | input | 8 | Memory address field |
| cal_addr | input | 4 | Calibration register address |
| cmd_code | input | 4 | Last command code |
| ana_sel | input | 4 | Analog select field |
| win_code | input | 4 | Window length code |
| mem_byte | input | 8 | Memory data byte |
| temp_index | input | 8 | Temperature index |
| rate_count | input | 8 | Learned bit-clock count |
| bit_period | input | PERW | Cycles per serial bit |
| line_out | output | 1 | Serial data out |
| line_oe | output | 1 | Serial driver enable |
| ana_oe | output | 1 | Analog output enable |
| busy | output | 1 | Reply or window in progress |

## Verification
The assertions assume two things about the inputs. First, requests are single-cycle strobes from a receiver that respects `busy`. Second, `bit_period` stays constant while `busy` is 1, since the frame and gap properties count on a stable period. The bench changes `bit_period` and the fields only between transactions. It raises strobes during `busy` only to show that they are ignored. The continuous-mode window is shortened through CONT_WIN_LOG2 so that its full length fits the run.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   localparam int FIELD_W       = 4;
   localparam int BYTE_W        = 8;
   localparam int BITS_PER_BYTE = 8;
   localparam int FRAME_BITS    = BYTE_W + 2;
   localparam int SEL_W         = 4;
   localparam logic [BYTE_W-1:0] CHECK_BYTE = 8'hCA;
   localparam logic [BYTE_W-1:0] EMPTY_BYTE = 8'h00;
   localparam logic [FIELD_W-1:0] CONT_CODE = '1;
   // tick counter must hold 8*(2^15+1)-1
   localparam int TCW = (1 << FIELD_W) - 1 + 4;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_GAP,
      ST_FRAME,
      ST_AWIN
   } rbs_state_e;
endpackage

// File: rtl/rbs_reply_mux.sv
module rbs_reply_mux
   import rbs_pkg::*;
(
   input  logic [SEL_W-1:0]   sel,
   input  logic [15:0]        hold_word,
   input  logic [7:0]         mem_addr,
   input  logic [FIELD_W-1:0] cal_addr,
   input  logic [FIELD_W-1:0] cmd_code,
   input  logic [FIELD_W-1:0] ana_sel,
   input  logic [FIELD_W-1:0] win_code,
   input  logic [7:0]         mem_byte,
   input  logic [7:0]         temp_index,
   input  logic [7:0]         rate_count,
   output logic [BYTE_W-1:0]  reply
);
   always_comb begin
      unique case (sel)
         4'h0:    reply = hold_word[7:0];
         4'h1:    reply = hold_word[15:8];
         4'h2:    reply = {mem_addr[7:4], cal_addr};
         4'h3:    reply = {cmd_code, sel};
         4'h4:    reply = {ana_sel, win_code};
         4'h5:    reply = mem_addr;
         4'h6:    reply = mem_byte;
         4'h7:    reply = temp_index;
         4'h8:    reply = rate_count;
         4'h9:    reply = EMPTY_BYTE;
         default: reply = CHECK_BYTE;
      endcase
   end
endmodule

// File: rtl/rbs_bit_timer.sv
module rbs_bit_timer #(
   parameter int PERW = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PERW-1:0] period,
   output logic            tick
);
   logic [PERW-1:0] cnt_q;
   logic [PERW-1:0] last;

   // a zero period is treated as one cycle
   assign last = (period == '0) ? '0 : period - 1'b1;
   assign tick = run && (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!run)  cnt_q <= '0;
      else if (tick)  cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/rbs_window_len.sv
module rbs_window_len
   import rbs_pkg::*;
#(
   parameter int CONT_WIN_LOG2 = 15,
   parameter bit CONT_ENABLE   = 1'b1
) (
   input  logic [FIELD_W-1:0] code,
   output logic [TCW-1:0]     last_tick,
   output logic               cont
);
   logic [FIELD_W-1:0] expo;
   logic [TCW-1:0]     nbytes;

   generate
      if (CONT_ENABLE) begin : g_cont
         assign cont = (code == CONT_CODE);
         assign expo = cont ? FIELD_W'(CONT_WIN_LOG2) : code;
      end else begin : g_plain
         assign cont = 1'b0;
         assign expo = code;
      end
   endgenerate

   assign nbytes    = (TCW'(1) << expo) + TCW'(1);
   assign last_tick = (nbytes << $clog2(BITS_PER_BYTE)) - TCW'(1);
endmodule

// File: rtl/readback_window_seq.sv
module readback_window_seq
   import rbs_pkg::*;
#(
   parameter int PERW          = 12,
   parameter int CONT_WIN_LOG2 = 15,
   parameter bit CONT_ENABLE   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_req,
   input  logic            ana_req,
   input  logic [3:0]      rd_sel,
   input  logic [15:0]     hold_word,
   input  logic [7:0]      mem_addr,
   input  logic [3:0]      cal_addr,
   input  logic [3:0]      cmd_code,
   input  logic [3:0]      ana_sel,
   input  logic [3:0]      win_code,
   input  logic [7:0]      mem_byte,
   input  logic [7:0]      temp_index,
   input  logic [7:0]      rate_count,
   input  logic [PERW-1:0] bit_period,
   output logic            line_out,
   output logic            line_oe,
   output logic            ana_oe,
   output logic            busy
);
   localparam logic [TCW-1:0] GAP_LAST   = TCW'(BITS_PER_BYTE - 1);
   localparam logic [TCW-1:0] FRAME_LAST = TCW'(FRAME_BITS - 1);

   generate
      if (PERW < 1 || PERW > 16) begin : g_bad_perw
         $error("PERW must lie in 1..16");
      end
      if (CONT_WIN_LOG2 < 1 || CONT_WIN_LOG2 > 15) begin : g_bad_cont
         $error("CONT_WIN_LOG2 must lie in 1..15");
      end
   endgenerate

   rbs_state_e            state_q;
   logic [TCW-1:0]        tcnt_q;
   logic [FRAME_BITS-1:0] frame_q;
   logic                  ana_q;
   logic                  cont_q;
   logic [TCW-1:0]        wlast_q;
   logic                  tick;
   logic [BYTE_W-1:0]     reply;
   logic [TCW-1:0]        wlast;
   logic                  wcont;

   rbs_reply_mux u_mux (
      .sel        (rd_sel),
      .hold_word  (hold_word),
      .mem_addr   (mem_addr),
      .cal_addr   (cal_addr),
      .cmd_code   (cmd_code),
      .ana_sel    (ana_sel),
      .win_code   (win_code),
      .mem_byte   (mem_byte),
      .temp_index (temp_index),
      .rate_count (rate_count),
      .reply      (reply)
   );

   rbs_bit_timer #(.PERW(PERW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (state_q != ST_IDLE),
      .period (bit_period),
      .tick   (tick)
   );

   rbs_window_len #(
      .CONT_WIN_LOG2 (CONT_WIN_LOG2),
      .CONT_ENABLE   (CONT_ENABLE)
   ) u_wlen (
      .code      (win_code),
      .last_tick (wlast),
      .cont      (wcont)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tcnt_q  <= '0;
         frame_q <= '1;
         ana_q   <= 1'b0;
         cont_q  <= 1'b0;
         wlast_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               tcnt_q <= '0;
               if (rd_req) begin
                  // readback has priority over a same-cycle analog request
                  state_q <= ST_GAP;
                  frame_q <= {1'b1, reply, 1'b0};
                  ana_q   <= 1'b0;
               end else if (ana_req) begin
                  state_q <= ST_AWIN;
                  ana_q   <= 1'b1;
                  cont_q  <= wcont;
                  wlast_q <= wlast;
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (tcnt_q == GAP_LAST) begin
                     state_q <= ST_FRAME;
                     tcnt_q  <= '0;
                  end else begin
                     tcnt_q <= tcnt_q + 1'b1;
                  end
               end
            end
            ST_FRAME: begin
               if (tick) begin
                  frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
                  if (tcnt_q == FRAME_LAST) begin
                     state_q <= ST_IDLE;
                     tcnt_q  <= '0;
                  end else begin
                     tcnt_q <= tcnt_q + 1'b1;
                  end
               end
            end
            ST_AWIN: begin
               if (tick) begin
                  if (tcnt_q == wlast_q) begin
                     state_q <= ST_IDLE;
                     tcnt_q  <= '0;
                     if (!cont_q) ana_q <= 1'b0;
                  end else begin
                     tcnt_q <= tcnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign line_oe  = (state_q == ST_FRAME);
   assign line_out = (state_q == ST_FRAME) ? frame_q[0] : 1'b1;
   assign ana_oe   = ana_q;
endmodule

// File: rtl/readback_window_seq_chk.sv
module readback_window_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic rd_req,
   input logic ana_req,
   input logic line_out,
   input logic line_oe,
   input logic ana_oe,
   input logic busy
);
   assert_oe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_oe && ana_oe));

   assert_released_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !line_oe |-> line_out);

   assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_oe) |-> !line_out);

   assert_stop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_oe) |-> $past(line_out));

   assert_gap_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !line_oe);

   assert_drive_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      line_oe |-> busy);

   assert_read_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && rd_req && ana_req) |=> !ana_oe);

   assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ana_oe && ana_req) |=> !ana_oe);
endmodule

bind readback_window_seq readback_window_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_req   (rd_req),
   .ana_req  (ana_req),
   .line_out (line_out),
   .line_oe  (line_oe),
   .ana_oe   (ana_oe),
   .busy     (busy)
);

// File: tb/readback_window_seq_test.sv
module readback_window_seq_test;
   localparam int PERW = 12;
   localparam int CONT = 6;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            rd_req, ana_req;
   logic [3:0]      rd_sel, cal_addr, cmd_code, ana_sel, win_code;
   logic [15:0]     hold_word;
   logic [7:0]      mem_addr, mem_byte, temp_index, rate_count;
   logic [PERW-1:0] bit_period;
   logic            line_out, line_oe, ana_oe, busy;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   readback_window_seq #(.PERW(PERW), .CONT_WIN_LOG2(CONT)) uut (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .ana_req(ana_req),
      .rd_sel(rd_sel), .hold_word(hold_word), .mem_addr(mem_addr),
      .cal_addr(cal_addr), .cmd_code(cmd_code), .ana_sel(ana_sel),
      .win_code(win_code), .mem_byte(mem_byte), .temp_index(temp_index),
      .rate_count(rate_count), .bit_period(bit_period),
      .line_out(line_out), .line_oe(line_oe), .ana_oe(ana_oe), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // byte expected per R4/R5
   function automatic logic [7:0] exp_byte(input logic [3:0] s);
      case (s)
         4'h0: return hold_word[7:0];
         4'h1: return hold_word[15:8];
         4'h2: return {mem_addr[7:4], cal_addr};
         4'h3: return {cmd_code, s};
         4'h4: return {ana_sel, win_code};
         4'h5: return mem_addr;
         4'h6: return mem_byte;
         4'h7: return temp_index;
         4'h8: return rate_count;
         4'h9: return 8'h00;
         default: return 8'hCA;
      endcase
   endfunction

   task automatic set_fields(input int seed);
      hold_word  = 16'(seed * 97 + 16'h1234);
      mem_addr   = 8'(seed * 13 + 5);
      cal_addr   = 4'(seed + 9);
      cmd_code   = 4'(seed * 3);
      ana_sel    = 4'(seed * 5 + 1);
      win_code   = 4'(seed * 7);
      mem_byte   = 8'(seed * 29 + 7);
      temp_index = 8'(seed * 41);
      rate_count = 8'(seed * 53 + 11);
   endtask

   // mode 0: plain, 1: extra strobes during busy (R8), 2: both strobes at once (R9)
   task automatic run_read(input int ptr, input int p, input int mode);
      int pe = (p == 0) ? 1 : p;
      logic [7:0] eb;
      set_fields(ptr * 37 + p * 11 + mode);
      if (mode == 2) win_code = 4'h0;
      rd_sel = 4'(ptr);
      bit_period = PERW'(p);
      eb = exp_byte(4'(ptr));
      rd_req = 1'b1;
      ana_req = (mode == 2);
      @(posedge clk);
      @(negedge clk);
      rd_req = 1'b0;
      ana_req = 1'b0;
      for (int m = 0; m <= 18 * pe; m++) begin
         bit eo = (m >= 8 * pe) && (m < 18 * pe);
         int b = (m - 8 * pe) / pe;
         bit ev = !eo ? 1'b1 : (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : eb[b-1];
         string rq = (mode == 1) ? "R8" : (mode == 2) ? "R9" : (p == 0) ? "R10" :
                     (ptr >= 9) ? "R5" : "R4";
         chk(line_oe == eo, eo ? "R3 line_oe" : "R2 line_oe", line_oe, eo);
         chk(line_out == ev, rq, line_out, ev);
         chk(busy == (m < 18 * pe), "R3 busy", busy, m < 18 * pe);
         chk(ana_oe == 1'b0, rq, ana_oe, 0);
         if (mode == 1 && m == 3) begin
            rd_req = 1'b1; ana_req = 1'b1; rd_sel = rd_sel ^ 4'h1;
            hold_word = ~hold_word; mem_addr = ~mem_addr;
         end
         if (mode == 1 && m == 4) begin
            rd_req = 1'b0; ana_req = 1'b0;
         end
         @(negedge clk);
      end
   endtask

   task automatic run_ana(input int t, input int p);
      int e = (t == 15) ? CONT : t;
      int n = 8 * ((1 << e) + 1) * p;
      string rq = (t == 15) ? "R7" : "R6";
      bit_period = PERW'(p);
      win_code = 4'(t);
      ana_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ana_req = 1'b0;
      for (int m = 0; m <= n + 3; m++) begin
         bit ea = (m < n) || (t == 15);
         chk(busy == (m < n), rq, busy, m < n);
         chk(ana_oe == ea, rq, ana_oe, ea);
         chk(line_oe == 1'b0 && line_out == 1'b1, "R6 line", {line_oe, line_out}, 1);
         @(negedge clk);
      end
   endtask

   initial begin
      rst_n = 1'b0; rd_req = 1'b0; ana_req = 1'b0; rd_sel = '0;
      bit_period = PERW'(1);
      set_fields(0);
      repeat (3) @(negedge clk);
      chk(line_oe == 0 && ana_oe == 0 && busy == 0 && line_out == 1, "R1",
          {line_oe, ana_oe, busy, line_out}, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(line_oe == 0 && ana_oe == 0 && busy == 0 && line_out == 1, "R1",
          {line_oe, ana_oe, busy, line_out}, 1);
      for (int p = 1; p <= 3; p++)
         for (int ptr = 0; ptr < 16; ptr++)
            run_read(ptr, p, 0);
      run_read(5, 2, 1);
      run_read(8, 1, 2);
      run_read(7, 0, 0);
      for (int t = 0; t <= 5; t++) run_ana(t, 1);
      run_ana(3, 2);
      run_ana(10, 1);
      run_ana(15, 1);
      repeat (20) @(negedge clk);
      chk(ana_oe == 1'b1 && busy == 1'b0, "R7 hold", {ana_oe, busy}, 2);
      run_read(2, 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule